// File: doc/BRIEF.md
# Single-Slot Packet Timestamp Capture

This block latches the running 64-bit system time when a packet event that should be timestamped passes the port, once for the receive direction and once for the transmit direction. Each direction has exactly one capture slot. When a capture happens the slot locks. It stays locked until the host reads the upper word of that stamp. Because of this lock, a stored stamp can only belong to one packet.

Packet parsing happens upstream. With each receive strobe the block is given pre-decoded fields: ethertype, a UDP flag, the destination port, a version-2 flag and the message-type nibble. Each transmit strobe marks a packet that is already selected for stamping. A configuration write programs, in one cycle, the two enables, the receive filter mode and a match word. The match word holds the message code and the UDP event port. The write also discards any pending stamps.

The host reads through a 2-bit address. Bit 1 selects the direction and bit 0 selects the half.

Top module: `ts_capture`

## Requirements
- R1: After reset both valid flags are 0, both directions are disabled, and all four stamp words read 0.
- R2: An enabled event on a free slot stores the system time present in the strobe cycle. The valid flag reads 1 from the next cycle.
- R3: While a slot is valid, later events on that direction are ignored and its stamp does not change.
- R4: A read at an address with bit 0 = 1 (upper half) frees that direction's slot in the following cycle. A read with bit 0 = 0 (lower half) leaves the flag set.
- R5: Receive mode 0 (L4, version 1) matches when all of these hold: UDP is set, the destination port equals the programmed port, the version-2 flag is 0, and the message type equals the programmed code.
- R6: Receive mode 1 (version 2, coded) matches when the version-2 flag is 1, the message type equals the code, and either the ethertype is 0x88F7 or a UDP packet is sent to the programmed port.
- R7: Receive mode 2 (version 2, all events) matches on either transport when the version-2 flag is 1 and message-type bit 3 is 0 (types 0 to 7).
- R8: Receive mode 3 never matches.
- R9: A direction whose enable bit is written 0 never sets its valid flag.
- R10: A configuration write clears both valid flags. An event in the same cycle as the write is dropped.
- R11: An event in the same cycle as an upper-half read of the same direction is dropped. The slot is free afterwards.
- R12: Read address encoding: bit 1 selects receive (0) or transmit (1), and bit 0 selects the lower (0) or upper (1) 32 bits.
- R13: Match-word layout: bits 3:0 hold the message code and bits 31:16 hold the UDP event port (319 for standard event traffic).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sysTime | input | 64 | Running system time |
| cfgWr | input | 1 | Configuration write strobe |
| cfgTxEn | input | 1 | Transmit capture enable |
| cfgRxEn | input | 1 | Receive capture enable |
| cfgRxMode | input | 2 | Receive filter mode |
| cfgMatchWord | input | 32 | Message code and UDP port |
| txEvt | input | 1 | Transmit event strobe |
| rxEvt | input | 1 | Receive event strobe |
| rxEtype | input | 16 | Decoded ethertype |
| rxIsUdp | input | 1 | Packet is UDP |
| rxDstPort | input | 16 | UDP destination port |
| rxIsV2 | input | 1 | Version-2 message |
| rxMsgType | input | 4 | Message-type nibble |
| rdEn | input | 1 | Host read strobe |
| rdAddr | input | 2 | Read address {direction, half} |
| rdData | output | 32 | Selected stamp word |
| rxValid | output | 1 | Receive stamp held |
| txValid | output | 1 | Transmit stamp held |

## Verification
Two pairs of functions can act in the same cycle: a capture strobe with the host's upper-half read that releases the slot, and a capture strobe with a configuration write. The bench drives each pair in one cycle. It judges the outcome by checking that the valid flag reads 0 afterwards and that no capture appears on the scoreboard. It then proves the slot is free again with a fresh capture whose stamp must match the time of its own strobe.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int NSIDE   = 2;
  localparam int SIDE_RX = 0;
  localparam int SIDE_TX = 1;

  typedef enum logic [1:0] {
    MODE_L4V1  = 2'd0,
    MODE_V2MSG = 2'd1,
    MODE_V2EVT = 2'd2,
    MODE_RSVD  = 2'd3
  } rxMode_e;

  typedef struct packed {
    logic capTx;
    logic capRx;
  } capStrobe_t;
endpackage

// File: rtl/ts_cap_ctrl.sv
module ts_cap_ctrl
  import ts_cap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int MSG_W = 4,
  parameter int PORT_W = 16,
  parameter int ETYPE_W = 16,
  parameter logic [ETYPE_W-1:0] PTP_ETYPE = 16'h88F7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWr,
  input  logic               cfgTxEn,
  input  logic               cfgRxEn,
  input  logic [1:0]         cfgRxMode,
  input  logic [WORD_W-1:0]  cfgMatchWord,
  input  logic               txEvt,
  input  logic               rxEvt,
  input  logic [ETYPE_W-1:0] rxEtype,
  input  logic               rxIsUdp,
  input  logic [PORT_W-1:0]  rxDstPort,
  input  logic               rxIsV2,
  input  logic [MSG_W-1:0]   rxMsgType,
  input  logic               rdEn,
  input  logic [1:0]         rdAddr,
  output capStrobe_t         strobe,
  output logic [NSIDE-1:0]   validQ
);
  localparam int PORT_LSB = WORD_W - PORT_W;

  logic              txEnQ, rxEnQ;
  rxMode_e           modeQ;
  logic [MSG_W-1:0]  codeQ;
  logic [PORT_W-1:0] portQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnQ <= 1'b0;
      rxEnQ <= 1'b0;
      modeQ <= MODE_RSVD;
      codeQ <= '0;
      portQ <= '0;
    end else if (cfgWr) begin
      txEnQ <= cfgTxEn;
      rxEnQ <= cfgRxEn;
      modeQ <= rxMode_e'(cfgRxMode);
      codeQ <= cfgMatchWord[MSG_W-1:0];
      portQ <= cfgMatchWord[WORD_W-1:PORT_LSB];
    end
  end

  logic l2Hit, l4Hit, codeHit, rxHit;
  always_comb begin
    l2Hit   = (rxEtype == PTP_ETYPE);
    l4Hit   = rxIsUdp && (rxDstPort == portQ);
    codeHit = (rxMsgType == codeQ);
    unique case (modeQ)
      MODE_L4V1:  rxHit = l4Hit && !rxIsV2 && codeHit;
      MODE_V2MSG: rxHit = (l2Hit || l4Hit) && rxIsV2 && codeHit;
      MODE_V2EVT: rxHit = (l2Hit || l4Hit) && rxIsV2 && !rxMsgType[MSG_W-1];
      default:    rxHit = 1'b0;
    endcase
  end

  logic [NSIDE-1:0] relSide;
  always_comb begin
    relSide = '0;
    if (rdEn && rdAddr[0]) relSide[rdAddr[1]] = 1'b1;
  end

  always_comb begin
    strobe.capRx = rxEvt && rxEnQ && rxHit && !validQ[SIDE_RX] && !cfgWr;
    strobe.capTx = txEvt && txEnQ && !validQ[SIDE_TX] && !cfgWr;
  end

  logic [NSIDE-1:0] capVec;
  assign capVec = {strobe.capTx, strobe.capRx};

  for (genvar s = 0; s < NSIDE; s++) begin : g_valid
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             validQ[s] <= 1'b0;
      else if (cfgWr)        validQ[s] <= 1'b0;
      else if (relSide[s])   validQ[s] <= 1'b0;
      else if (capVec[s])    validQ[s] <= 1'b1;
    end
  end

  // R10
  cfg_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (validQ == '0));

  // R4
  rd_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 2'b01) |=> !validQ[SIDE_RX]);

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validQ[SIDE_TX] && !cfgWr && !(rdEn && rdAddr == 2'b11)) |=> validQ[SIDE_TX]);

  // R9
  rx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnQ && !validQ[SIDE_RX]) |=> !validQ[SIDE_RX]);
endmodule

// File: rtl/ts_cap_dp.sv
module ts_cap_dp
  import ts_cap_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] sysTime,
  input  capStrobe_t        strobe,
  input  logic [NSIDE-1:0]  validIn,
  input  logic [1:0]        rdAddr,
  output logic [WORD_W-1:0] rdData
);
  logic [TIME_W-1:0] stampQ [NSIDE];
  logic [NSIDE-1:0]  capVec;
  assign capVec = {strobe.capTx, strobe.capRx};

  for (genvar s = 0; s < NSIDE; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          stampQ[s] <= '0;
      else if (capVec[s]) stampQ[s] <= sysTime;
    end

    // R2
    stamp_take_chk: assert property (@(posedge clk) disable iff (!rstN)
      capVec[s] |=> (stampQ[s] == $past(sysTime)));

    // R3
    locked_no_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
      validIn[s] |-> !capVec[s]);
  end

  logic [TIME_W-1:0] selStamp;
  always_comb begin
    selStamp = stampQ[rdAddr[1]];
    rdData   = rdAddr[0] ? selStamp[TIME_W-1:TIME_W-WORD_W] : selStamp[WORD_W-1:0];
  end
endmodule

// File: rtl/ts_capture.sv
module ts_capture
  import ts_cap_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int WORD_W = 32,
  parameter int MSG_W = 4,
  parameter int PORT_W = 16,
  parameter int ETYPE_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIME_W-1:0]  sysTime,
  input  logic               cfgWr,
  input  logic               cfgTxEn,
  input  logic               cfgRxEn,
  input  logic [1:0]         cfgRxMode,
  input  logic [WORD_W-1:0]  cfgMatchWord,
  input  logic               txEvt,
  input  logic               rxEvt,
  input  logic [ETYPE_W-1:0] rxEtype,
  input  logic               rxIsUdp,
  input  logic [PORT_W-1:0]  rxDstPort,
  input  logic               rxIsV2,
  input  logic [MSG_W-1:0]   rxMsgType,
  input  logic               rdEn,
  input  logic [1:0]         rdAddr,
  output logic [WORD_W-1:0]  rdData,
  output logic               rxValid,
  output logic               txValid
);
  capStrobe_t       strobe;
  logic [NSIDE-1:0] validQ;

  ts_cap_ctrl #(
    .WORD_W(WORD_W), .MSG_W(MSG_W), .PORT_W(PORT_W), .ETYPE_W(ETYPE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWr(cfgWr), .cfgTxEn(cfgTxEn), .cfgRxEn(cfgRxEn),
    .cfgRxMode(cfgRxMode), .cfgMatchWord(cfgMatchWord),
    .txEvt(txEvt), .rxEvt(rxEvt), .rxEtype(rxEtype), .rxIsUdp(rxIsUdp),
    .rxDstPort(rxDstPort), .rxIsV2(rxIsV2), .rxMsgType(rxMsgType),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .strobe(strobe), .validQ(validQ)
  );

  ts_cap_dp #(.TIME_W(TIME_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .sysTime(sysTime), .strobe(strobe),
    .validIn(validQ), .rdAddr(rdAddr), .rdData(rdData)
  );

  assign rxValid = validQ[SIDE_RX];
  assign txValid = validQ[SIDE_TX];
endmodule

// File: tb/sim_ts_capture.sv
`timescale 1ns/1ps
module sim_ts_capture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] sysTime = 64'h0000_0000_FFFF_FF00;
  logic        cfgWr = 0, cfgTxEn = 0, cfgRxEn = 0;
  logic [1:0]  cfgRxMode = 0;
  logic [31:0] cfgMatchWord = 0;
  logic        txEvt = 0, rxEvt = 0;
  logic [15:0] rxEtype = 0;
  logic        rxIsUdp = 0;
  logic [15:0] rxDstPort = 0;
  logic        rxIsV2 = 0;
  logic [3:0]  rxMsgType = 0;
  logic        rdEn = 0;
  logic [1:0]  rdAddr = 0;
  logic [31:0] rdData;
  logic        rxValid, txValid;

  int nChk = 0, nBad = 0;
  logic [63:0] expRx[$], expTx[$];
  logic [63:0] curRx, curTx;
  logic prevRx = 0, prevTx = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) sysTime <= sysTime + 64'd3;

  ts_capture u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected stamps as the design raises its valid flags
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (rxValid && !prevRx) begin
        if (expRx.size() == 0) chk(0, "R3/R9 unexpected rx capture", 1, 0);
        else curRx = expRx.pop_front();
      end
      if (txValid && !prevTx) begin
        if (expTx.size() == 0) chk(0, "R3/R9 unexpected tx capture", 1, 0);
        else curTx = expTx.pop_front();
      end
    end
    prevRx = rxValid;
    prevTx = txValid;
  end

  task automatic cfg(input bit tx, input bit rx, input logic [1:0] m, input logic [15:0] port, input logic [3:0] code);
    @(negedge clk);
    cfgWr = 1; cfgTxEn = tx; cfgRxEn = rx; cfgRxMode = m;
    cfgMatchWord = {port, 12'h0, code};
    @(negedge clk);
    cfgWr = 0;
  endtask

  task automatic txPulse(input bit expect_cap);
    @(negedge clk);
    txEvt = 1;
    if (expect_cap) expTx.push_back(sysTime);
    @(negedge clk);
    txEvt = 0;
  endtask

  task automatic rxPulse(input logic [15:0] et, input bit udp, input logic [15:0] port,
                         input bit v2, input logic [3:0] mt, input bit expect_cap);
    @(negedge clk);
    rxEvt = 1; rxEtype = et; rxIsUdp = udp; rxDstPort = port; rxIsV2 = v2; rxMsgType = mt;
    if (expect_cap) expRx.push_back(sysTime);
    @(negedge clk);
    rxEvt = 0;
  endtask

  task automatic rdWord(input bit side, input bit hi, output logic [31:0] d);
    @(negedge clk);
    rdAddr = {side, hi}; rdEn = 1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 0;
  endtask

  // R12: lower then upper half; R4: lower read keeps flag, upper frees slot
  task automatic readCheck(input bit side, input string req);
    logic [31:0] lo, hi;
    logic [63:0] exp;
    exp = side ? curTx : curRx;
    rdWord(side, 1'b0, lo);
    chk(lo == exp[31:0], {req, " R12 low word"}, {32'h0, lo}, {32'h0, exp[31:0]});
    chk((side ? txValid : rxValid) == 1'b1, "R4 low read keeps valid", 0, 1);
    rdWord(side, 1'b1, hi);
    chk(hi == exp[63:32], {req, " R12 high word"}, {32'h0, hi}, {32'h0, exp[63:32]});
    chk((side ? txValid : rxValid) == 1'b0, "R4 high read frees slot", 1, 0);
  endtask

  task automatic expectIdle(input string req);
    @(negedge clk);
    chk(rxValid == 0 && txValid == 0, req, {rxValid, txValid}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chk(rxValid == 0 && txValid == 0, "R1 valid flags", {rxValid, txValid}, 0);
    for (int a = 0; a < 4; a++) begin
      rdAddr = a[1:0]; #1;
      chk(rdData == 0, "R1 stamp word", {32'h0, rdData}, 0);
    end
    txPulse(0);
    rxPulse(16'h88F7, 1, 16'd319, 1, 4'h0, 0);
    expectIdle("R1/R9 disabled after reset");

    // R2 / R13
    cfg(1, 1, 2'd0, 16'd319, 4'h0);
    txPulse(1);
    readCheck(1, "R2 tx stamp");

    // R3: second event while locked ignored
    txPulse(1);
    repeat (3) @(negedge clk);
    txPulse(0);
    readCheck(1, "R3 first stamp kept");

    // R5 mode 0
    rxPulse(16'h0800, 1, 16'd319, 0, 4'h0, 1);
    readCheck(0, "R5 L4 v1 match");
    rxPulse(16'h0800, 1, 16'd320, 0, 4'h0, 0); expectIdle("R5 wrong port");
    rxPulse(16'h0800, 1, 16'd319, 1, 4'h0, 0); expectIdle("R5 v2 rejected");
    rxPulse(16'h0800, 1, 16'd319, 0, 4'h1, 0); expectIdle("R5 wrong code");
    rxPulse(16'h88F7, 0, 16'd319, 0, 4'h0, 0); expectIdle("R5 L2 rejected");
    cfg(1, 1, 2'd0, 16'd320, 4'h0);
    rxPulse(16'h0800, 1, 16'd320, 0, 4'h0, 1);
    readCheck(0, "R13 programmed port");

    // R6 mode 1, code 1
    cfg(1, 1, 2'd1, 16'd319, 4'h1);
    rxPulse(16'h88F7, 0, 16'd0, 1, 4'h1, 1);
    readCheck(0, "R6 L2 match");
    rxPulse(16'h0800, 1, 16'd319, 1, 4'h1, 1);
    readCheck(0, "R6 L4 match");
    rxPulse(16'h88F7, 0, 16'd0, 1, 4'h0, 0); expectIdle("R6 wrong code");
    rxPulse(16'h88F7, 0, 16'd0, 0, 4'h1, 0); expectIdle("R6 v1 rejected");
    rxPulse(16'h0800, 0, 16'd319, 1, 4'h1, 0); expectIdle("R6 no transport");

    // R7 mode 2
    cfg(1, 1, 2'd2, 16'd319, 4'h0);
    rxPulse(16'h88F7, 0, 16'd0, 1, 4'h3, 1);
    readCheck(0, "R7 event type");
    rxPulse(16'h0800, 1, 16'd319, 1, 4'h8, 0); expectIdle("R7 general type");

    // R8 mode 3
    cfg(1, 1, 2'd3, 16'd319, 4'h0);
    rxPulse(16'h88F7, 1, 16'd319, 1, 4'h0, 0); expectIdle("R8 reserved mode");

    // R9 disabled
    cfg(0, 0, 2'd2, 16'd319, 4'h0);
    rxPulse(16'h88F7, 0, 16'd0, 1, 4'h0, 0);
    txPulse(0);
    expectIdle("R9 both disabled");

    // R10: pending stamps flushed, event with write dropped
    cfg(1, 1, 2'd2, 16'd319, 4'h0);
    rxPulse(16'h88F7, 0, 16'd0, 1, 4'h0, 1);
    txPulse(1);
    @(negedge clk);
    chk(rxValid && txValid, "R10 both pending", {rxValid, txValid}, 2'b11);
    cfgWr = 1; txEvt = 1;
    @(negedge clk);
    cfgWr = 0; txEvt = 0;
    chk(rxValid == 0 && txValid == 0, "R10 flush and drop", {rxValid, txValid}, 0);
    expectIdle("R10 nothing captured");

    // R11: release and event in one cycle
    txPulse(1);
    @(negedge clk);
    rdAddr = 2'b11; rdEn = 1; txEvt = 1;
    @(negedge clk);
    rdEn = 0; txEvt = 0;
    chk(txValid == 0, "R11 event dropped at release", txValid, 0);
    txPulse(1);
    readCheck(1, "R11 slot free again");

    repeat (3) @(negedge clk);
    chk(expRx.size() == 0 && expTx.size() == 0, "R2 missing capture",
        expRx.size() + expTx.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule